// File: doc/BRIEF.md
# Asymmetric Speech Analysis Windowing Unit

This block sits at the front of a speech analysis chain. It accepts a stream of signed 16-bit speech samples over a valid/ready handshake. It halves each sample and stores it in a circular history of the latest 240 values. Once the history is full, and after every further 80 accepted samples, it streams one analysis frame of 240 windowed values. Each value is a stored sample multiplied by a fixed window coefficient. Consecutive frames therefore share 160 samples.

The window is asymmetric. Positions 0 to 199 follow a rising half raised-cosine (Hamming) shape, and positions 200 to 239 follow a falling quarter cosine. The coefficients live in a 256-word by 16-bit table that is built when the design is elaborated, and only the first 240 words are read. A single multiplier serves the whole frame. Each Q15 product is rounded to nearest and saturated back to 16 bits.

The output stream carries start-of-frame and end-of-frame flags and can be stalled by the consumer. If a frame is still streaming when the next frame boundary is due, the input handshake is held off. No history entry is overwritten before it has been read.

Top module: `speech_window_unit`

## Requirements
- R1: Each accepted sample is halved by an arithmetic right shift of one bit before storage (so -1 stays -1, -3 becomes -2, -32768 becomes -16384 and 32767 becomes 16383).
- R2: After reset no output is produced until 240 samples have been accepted; the 240th accepted sample starts the first frame.
- R3: After the first frame, a new frame starts on every 80th accepted sample. Frame position n = 0 holds the oldest of the latest 240 stored samples and n = 239 holds the newest.
- R4: The coefficient for position n is round(32768·w(n)), capped at 32767. For n = 0..199, w(n) = 0.54 − 0.46·cos(2πn/399). For n = 200..239, w(n) = cos(2π(n−200)/159). Table entries 240..255 are zero and are never read.
- R5: Each output value is (sample·coef + 16384) arithmetically shifted right by 15, saturated to [−32768, 32767].
- R6: A frame is exactly 240 outputs in position order. out_sof is 1 only on n = 0 and out_eof is 1 only on n = 239.
- R7: While out_valid is 1 and out_ready is 0, out_data, out_sof and out_eof hold their values and out_valid stays 1.
- R8: in_ready is 0 while a frame is streaming and the next accepted sample would start a new frame, or would overwrite a history entry the frame has not yet read. No accepted sample is lost.
- R9: A synchronous active-high reset clears the history and counters. The cycle after reset, out_valid is 0 and in_ready is 1, and the next frame again needs 240 accepted samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can accept a sample this cycle |
| in_data | input | 16 | Signed PCM sample |
| out_valid | output | 1 | Windowed value present |
| out_ready | input | 1 | Consumer accepts the value this cycle |
| out_data | output | 16 | Signed windowed value |
| out_sof | output | 1 | First value of a frame (n = 0) |
| out_eof | output | 1 | Last value of a frame (n = 239) |

## Verification
The hardest state to reach from the ports is a frame boundary that arrives while the previous frame is still held back by the consumer. In that state the history write pointer is chasing the frame's read position. The bench reaches it by driving out_ready low about three cycles in four from a pseudo-random sequence while feeding samples back to back. The input stall then shows up at in_ready. Every value of every frame is compared against a model built from the accepted samples. A lost or overwritten sample would show as a wrong product at the matching frame position.

// File: rtl/swin_pkg.sv
package swin_pkg;

    localparam int SAMPLE_W  = 16;
    localparam int COEF_W    = 16;
    localparam int FRAC_W    = 15;
    localparam int WIN_LEN   = 240;
    localparam int HOP_LEN   = 80;
    localparam int ROM_DEPTH = 256;
    localparam int RISE_LEN  = 200;
    localparam int RISE_DEN  = 399;
    localparam int FALL_DEN  = 159;

    // fixed-point constants in Q30
    localparam longint ONE_Q30  = 64'sd1073741824;
    localparam longint TWOPI_Q30 = 64'sd6746518852;
    localparam longint K054_Q30 = 64'sd579820585;
    localparam longint K046_Q30 = 64'sd493921239;

    typedef logic signed [SAMPLE_W-1:0] sample_t;
    typedef logic signed [COEF_W-1:0]   coef_t;

    typedef struct packed {
        logic signed [SAMPLE_W-1:0] data;
        logic                       sof;
        logic                       eof;
    } win_out_t;

    // cos(2*pi*num/den) in Q30, folded into the first quadrant then series
    function automatic longint cos_turn_q30(longint num, longint den);
        longint a;
        longint b;
        longint x;
        longint term;
        longint sum;
        logic   neg;
        a   = num % den;
        b   = den;
        neg = 1'b0;
        if (2 * a > b) a = b - a;
        if (4 * a > b) begin
            neg = 1'b1;
            a   = b - 2 * a;
            b   = 2 * b;
        end
        x    = (TWOPI_Q30 * a) / b;
        term = ONE_Q30;
        sum  = term;
        for (int i = 1; i <= 8; i++) begin
            term = (term * x) >>> 30;
            term = (term * x) >>> 30;
            term = -(term / longint'(2 * i * (2 * i - 1)));
            sum  = sum + term;
        end
        return neg ? -sum : sum;
    endfunction

    function automatic coef_t coef_q15(int n);
        longint w;
        longint q;
        if (n < RISE_LEN)
            w = K054_Q30 - ((K046_Q30 * cos_turn_q30(longint'(n), longint'(RISE_DEN))) >>> 30);
        else if (n < WIN_LEN)
            w = cos_turn_q30(longint'(n - RISE_LEN), longint'(FALL_DEN));
        else
            w = 0;
        q = (w + 64'sd16384) >>> 15;
        if (q > 32767) q = 32767;
        if (q < 0) q = 0;
        return coef_t'(q);
    endfunction

    function automatic sample_t round_sat(logic signed [SAMPLE_W+COEF_W-1:0] p);
        logic signed [SAMPLE_W+COEF_W:0] t;
        logic signed [SAMPLE_W+COEF_W:0] s;
        t = {p[SAMPLE_W+COEF_W-1], p} + (SAMPLE_W+COEF_W+1)'(1 << (FRAC_W - 1));
        s = t >>> FRAC_W;
        if (s > (SAMPLE_W+COEF_W+1)'(2 ** (SAMPLE_W - 1) - 1))
            return sample_t'({1'b0, {(SAMPLE_W-1){1'b1}}});
        else if (s < -(SAMPLE_W+COEF_W+1)'(2 ** (SAMPLE_W - 1)))
            return sample_t'({1'b1, {(SAMPLE_W-1){1'b0}}});
        else
            return sample_t'(s[SAMPLE_W-1:0]);
    endfunction

endpackage

// File: rtl/swin_history.sv
module swin_history
    import swin_pkg::*;
#(
    parameter int DEPTH = WIN_LEN,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  sample_t       wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output sample_t       rdata
);

    sample_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            rdata <= '0;
        end else begin
            if (we) mem[waddr] <= wdata;
            if (re) rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/swin_coef_rom.sv
module swin_coef_rom
    import swin_pkg::*;
#(
    parameter int DEPTH = ROM_DEPTH,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          re,
    input  logic [AW-1:0] addr,
    output coef_t         rdata
);

    coef_t table_w [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        localparam coef_t C = coef_q15(i);
        assign table_w[i] = C;
    end

    always_ff @(posedge clk) begin
        if (re) rdata <= table_w[addr];
    end

endmodule

// File: rtl/swin_mul_round.sv
module swin_mul_round
    import swin_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  logic     in_valid,
    input  sample_t  sample,
    input  coef_t    coef,
    input  logic     first,
    input  logic     last,
    output logic     out_valid,
    output win_out_t out_word
);

    logic signed [SAMPLE_W+COEF_W-1:0] prod;

    assign prod = sample * coef;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_word  <= '0;
        end else if (en) begin
            out_valid     <= in_valid;
            out_word.data <= round_sat(prod);
            out_word.sof  <= first;
            out_word.eof  <= last;
        end
    end

endmodule

// File: rtl/speech_window_unit.sv
module speech_window_unit
    import swin_pkg::*;
#(
    parameter int WIN  = WIN_LEN,
    parameter int HOP  = HOP_LEN,
    parameter int ROMD = ROM_DEPTH
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic signed [SAMPLE_W-1:0] in_data,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic signed [SAMPLE_W-1:0] out_data,
    output logic                       out_sof,
    output logic                       out_eof
);

    localparam int IDX_W  = $clog2(WIN);
    localparam int CNT_W  = $clog2(WIN + 1);
    localparam int ROM_AW = $clog2(ROMD);
    localparam logic [IDX_W:0]   WIN_EXT  = (IDX_W+1)'(WIN);
    localparam logic [IDX_W-1:0] PTR_LAST = IDX_W'(WIN - 1);
    localparam logic [CNT_W-1:0] HOP_M1   = CNT_W'(HOP - 1);
    localparam logic [CNT_W-1:0] WIN_M1   = CNT_W'(WIN - 1);

    logic [IDX_W-1:0] wr_ptr;
    logic [IDX_W-1:0] wr_ptr_nx;
    logic [IDX_W-1:0] base_q;
    logic [IDX_W-1:0] rd_addr;
    logic [IDX_W:0]   rd_sum;
    logic [CNT_W-1:0] since_q;
    logic [CNT_W-1:0] limit_m1;
    logic [CNT_W-1:0] n_issue;
    logic [CNT_W-1:0] s1_n;
    logic             primed;
    logic             busy;
    logic             s1_valid;
    logic             accept;
    logic             trigger;
    logic             pipe_en;
    logic             issue_fire;
    sample_t          halved;
    sample_t          hist_q;
    coef_t            coef_q;
    win_out_t         res;

    // input side
    assign halved    = in_data >>> 1;
    assign in_ready  = !(busy && ((since_q == HOP_M1) || (since_q >= n_issue)));
    assign accept    = in_valid && in_ready;
    assign limit_m1  = primed ? HOP_M1 : WIN_M1;
    assign trigger   = accept && (since_q == limit_m1);
    assign wr_ptr_nx = (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;

    // read side
    assign pipe_en    = !out_valid || out_ready;
    assign issue_fire = busy && pipe_en;
    assign rd_sum     = {1'b0, base_q} + (IDX_W+1)'(n_issue);
    assign rd_addr    = (rd_sum >= WIN_EXT) ? IDX_W'(rd_sum - WIN_EXT) : IDX_W'(rd_sum);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr  <= '0;
            since_q <= '0;
            primed  <= 1'b0;
            busy    <= 1'b0;
            base_q  <= '0;
            n_issue <= CNT_W'(WIN);
        end else begin
            if (accept) begin
                wr_ptr  <= wr_ptr_nx;
                since_q <= trigger ? '0 : since_q + 1'b1;
            end
            if (trigger) begin
                primed  <= 1'b1;
                busy    <= 1'b1;
                base_q  <= wr_ptr_nx;
                n_issue <= '0;
            end else if (issue_fire) begin
                n_issue <= n_issue + 1'b1;
                if (n_issue == WIN_M1) busy <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_n     <= '0;
        end else if (pipe_en) begin
            s1_valid <= issue_fire;
            s1_n     <= n_issue;
        end
    end

    swin_history #(.DEPTH(WIN)) u_hist (
        .clk   (clk),
        .rst   (rst),
        .we    (accept),
        .waddr (wr_ptr),
        .wdata (halved),
        .re    (issue_fire),
        .raddr (rd_addr),
        .rdata (hist_q)
    );

    swin_coef_rom #(.DEPTH(ROMD)) u_rom (
        .clk   (clk),
        .re    (issue_fire),
        .addr  (ROM_AW'(n_issue)),
        .rdata (coef_q)
    );

    swin_mul_round u_mul (
        .clk       (clk),
        .rst       (rst),
        .en        (pipe_en),
        .in_valid  (s1_valid),
        .sample    (hist_q),
        .coef      (coef_q),
        .first     (s1_n == '0),
        .last      (s1_n == WIN_M1),
        .out_valid (out_valid),
        .out_word  (res)
    );

    assign out_data = res.data;
    assign out_sof  = res.sof;
    assign out_eof  = res.eof;

endmodule

// File: rtl/swin_checker.sv
module swin_checker #(
    parameter int WIN_LEN = 240,
    parameter int DATA_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              out_sof,
    input logic              out_eof
);

    localparam int CW = $clog2(WIN_LEN + 1);

    logic [CW-1:0] pos_cnt;

    always_ff @(posedge clk) begin
        if (rst) pos_cnt <= '0;
        else if (out_valid && out_ready) pos_cnt <= out_eof ? '0 : pos_cnt + 1'b1;
    end

    p_sof_first_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_sof) |-> (pos_cnt == '0));

    p_mid_nosof_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_sof) |-> (pos_cnt != '0));

    p_eof_last_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_eof) |-> (pos_cnt == CW'(WIN_LEN - 1)));

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sof) && $stable(out_eof)));

    p_reset_clear_r9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && in_ready));

endmodule

bind speech_window_unit swin_checker #(.WIN_LEN(WIN), .DATA_W(swin_pkg::SAMPLE_W)) u_chk (.*);

// File: tb/tb_speech_window_unit.sv
module tb_speech_window_unit;

    localparam int CLK_PERIOD = 10;
    localparam int WINL = 240;
    localparam int HOPL = 80;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic signed [15:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic signed [15:0] out_data;
    logic        out_sof;
    logic        out_eof;

    int checks = 0;
    int errors = 0;
    int mdl [8192];
    int acc_cnt = 0;
    int fr_idx = 0;
    int n_idx = 0;
    int frames_seen = 0;
    int stall_cnt = 0;
    int rdy_mode = 0;
    logic [15:0] lfsr_s = 16'hACE1;
    logic [15:0] lfsr_r = 16'h1D2B;

    always #(CLK_PERIOD/2) clk = ~clk;

    speech_window_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sof(out_sof), .out_eof(out_eof)
    );

    function automatic logic [15:0] step(logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    function automatic int ref_coef(int n);
        real w;
        int  q;
        if (n < 200) w = 0.54 - 0.46 * $cos(2.0 * 3.14159265358979 * n / 399.0);
        else         w = $cos(2.0 * 3.14159265358979 * (n - 200) / 159.0);
        q = $rtoi($floor(w * 32768.0 + 0.5));
        if (q > 32767) q = 32767;
        return q;
    endfunction

    function automatic int ref_out(int x, int n);
        longint p;
        longint e;
        p = longint'(x) * longint'(ref_coef(n));
        e = (p + 64'sd16384) >>> 15;
        if (e > 32767) e = 32767;
        if (e < -32768) e = -32768;
        return int'(e);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // output monitor and consumer; checks R4 R5 R6 R7 against the sample model
    initial begin : monitor
        bit prev_stall;
        logic signed [15:0] prev_data;
        logic prev_sof;
        logic prev_eof;
        prev_stall = 0;
        prev_data = '0;
        prev_sof = 0;
        prev_eof = 0;
        forever begin
            @(negedge clk);
            if (rst) begin
                fr_idx = 0; n_idx = 0; frames_seen = 0; prev_stall = 0; out_ready = 1'b1;
            end else begin
                if (prev_stall)
                    chk(out_valid && out_data == prev_data && out_sof == prev_sof && out_eof == prev_eof,
                        "R7 hold", int'(out_data), int'(prev_data));
                if (rdy_mode == 1) begin
                    lfsr_r = step(lfsr_r);
                    out_ready = lfsr_r[0] & lfsr_r[3];
                end else begin
                    out_ready = 1'b1;
                end
                if (out_valid && out_ready) begin
                    int x;
                    int e;
                    x = mdl[fr_idx * HOPL + n_idx];
                    e = ref_out(x, n_idx);
                    chk((int'(out_data) - e <= 1) && (e - int'(out_data) <= 1),
                        "R4/R5 value", int'(out_data), e);
                    chk(out_sof == (n_idx == 0) && out_eof == (n_idx == WINL - 1),
                        "R6 flags", {out_sof, out_eof}, {n_idx == 0, n_idx == WINL - 1});
                    if (n_idx == WINL - 1) begin
                        n_idx = 0; fr_idx++; frames_seen++;
                    end else begin
                        n_idx++;
                    end
                end
                prev_stall = out_valid && !out_ready;
                prev_data = out_data;
                prev_sof = out_sof;
                prev_eof = out_eof;
            end
        end
    end

    task automatic send(input int x);
        @(negedge clk);
        in_data = 16'(x);
        in_valid = 1'b1;
        while (!in_ready) begin
            stall_cnt++;
            @(negedge clk);
        end
        @(posedge clk);
        mdl[acc_cnt] = x >>> 1;  // R1: arithmetic halving in the model
        acc_cnt++;
        #1 in_valid = 1'b0;
    endtask

    task automatic send_rand(input int count);
        for (int i = 0; i < count; i++) begin
            lfsr_s = step(lfsr_s);
            send(int'($signed(lfsr_s)));
        end
    endtask

    task automatic idle(input int cyc);
        for (int i = 0; i < cyc; i++) @(negedge clk);
    endtask

    task automatic wait_frames(input int target);
        for (int i = 0; i < 3000 && frames_seen < target; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        acc_cnt = 0;
        idle(2);
        rst = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        @(negedge clk);
        chk(out_valid == 1'b0, "R9 out_valid after reset", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R9 in_ready after reset", int'(in_ready), 1);
    endtask

    task automatic t_first_frame();
        send_rand(WINL - 1);
        idle(30);
        chk(frames_seen == 0 && !out_valid, "R2 no output before 240 samples", frames_seen, 0);
        send_rand(1);
        wait_frames(1);
        chk(frames_seen == 1, "R2 first frame after 240th sample", frames_seen, 1);
    endtask

    task automatic t_hop();
        send_rand(HOPL - 1);
        idle(30);
        chk(frames_seen == 1, "R3 no frame before 80th new sample", frames_seen, 1);
        send_rand(1);
        wait_frames(2);
        chk(frames_seen == 2, "R3 second frame at hop", frames_seen, 2);
        send_rand(HOPL);
        wait_frames(3);
        chk(frames_seen == 3, "R3 third frame at hop", frames_seen, 3);
    endtask

    task automatic t_extremes();
        int vals [8] = '{32767, -32768, -1, -3, 1, 3, -2, 16384};
        for (int i = 0; i < HOPL; i++) send(vals[i % 8]);  // R1 corner samples at positions 160..239
        wait_frames(4);
        chk(frames_seen == 4, "R1 frame with extreme samples", frames_seen, 4);
    endtask

    task automatic t_backpressure();
        stall_cnt = 0;
        rdy_mode = 1;
        send_rand(5 * HOPL);
        rdy_mode = 0;
        wait_frames(9);
        idle(10);
        chk(stall_cnt > 0, "R8 input stalled while frame streams", stall_cnt, 1);
        chk(frames_seen == 9, "R8 no frame lost under backpressure", frames_seen, 9);
        chk(!out_valid, "R8 idle after drain", int'(out_valid), 0);
    endtask

    task automatic t_reset_mid();
        rdy_mode = 1;
        send_rand(HOPL);
        idle(40);
        chk(out_valid || frames_seen < 10, "R9 frame in flight before reset", frames_seen, 9);
        do_reset();
        rdy_mode = 0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R9 output cleared by reset", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R9 input open after reset", int'(in_ready), 1);
        send_rand(WINL - 1);
        idle(30);
        chk(frames_seen == 0, "R9 counters restart after reset", frames_seen, 0);
        send_rand(1);
        wait_frames(1);
        chk(frames_seen == 1, "R9 frame after refill", frames_seen, 1);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", frames_seen, -1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset_state();
        t_first_frame();
        t_hop();
        t_extremes();
        t_backpressure();
        t_reset_mid();
        idle(5);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule